// File: doc/BRIEF.md
# Host and Device Loopback Selector

This block is a test-path controller that sits around a port-multiplier routing datapath. It has one parallel dword interface toward the host link and one toward each of several device links. When no test mode is active, it passes traffic through unchanged with a single register stage.

Two loopback tests are available. In host-side loopback, every dword received from the host is sent straight back to the host. In device-side loopback, the dword that has crossed the routing logic toward one chosen device is sent back up to the host. In both modes the looped traffic is copied rather than diverted, so the forward paths keep carrying the same stream. A bypass control lets the device-side loopback take host data directly, so that the test does not depend on the frame-aware router.

Mode controls arrive as plain inputs. A new mode takes effect only in an idle cycle between host dwords. A one-cycle strobe marks each change.

Top module: `loopback_sel`

## Requirements
- R1: With no loopback active, `hostTxData/Valid` equals `muxUpData/Valid` and each device slot `devTxData/Valid[i]` equals `muxDownData/Valid[i]`. Each output follows its input one clock later. Device slot i occupies bits [i*W +: W].
- R2: With host-side loopback active, `hostTxData/Valid` equals `hostRxData/Valid` one clock later.
- R3: In every mode, `muxInData/Valid` equals `hostRxData/Valid` one clock later. In host-side loopback, all device slots still carry `muxDownData` one clock later.
- R4: With device-side loopback active and bypass off, `hostTxData/Valid` equals the chosen slot of `muxDownData/Valid` one clock later, and that device slot still carries it.
- R5: With device-side loopback active and bypass on, both the chosen device slot and `hostTxData/Valid` carry `hostRxData/Valid` one clock later. The other device slots carry `muxDownData`.
- R6: When several bits of `deepEnMask` are set, the lowest-numbered set bit chooses the turnaround port.
- R7: When `shallowEn` is high, host-side loopback is used and `deepEnMask` and `deepBypass` have no effect.
- R8: A changed request is applied only at a clock edge where `hostRxValid` is low. While `hostRxValid` stays high, the previous mode stays in force.
- R9: `modeChg` is high for exactly the one cycle after each edge at which the applied mode changes, and is low otherwise. A change of the chosen port or of the bypass setting while device-side loopback is active counts as a mode change.
- R10: After reset, all outputs are zero and no loopback is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| shallowEn | input | 1 | Request host-side loopback |
| deepEnMask | input | NPORT | Per-device request for device-side loopback |
| deepBypass | input | 1 | Device-side loopback takes host data directly |
| hostRxData | input | W | Dword received from host |
| hostRxValid | input | 1 | hostRxData is valid |
| hostTxData | output | W | Dword sent to host |
| hostTxValid | output | 1 | hostTxData is valid |
| muxInData | output | W | Host dword forwarded to router |
| muxInValid | output | 1 | muxInData is valid |
| muxUpData | input | W | Router output toward host |
| muxUpValid | input | 1 | muxUpData is valid |
| muxDownData | input | NPORT*W | Router outputs toward devices |
| muxDownValid | input | NPORT | Per-device valid of muxDownData |
| devTxData | output | NPORT*W | Dwords sent to devices |
| devTxValid | output | NPORT | Per-device valid of devTxData |
| modeChg | output | 1 | One-cycle strobe when the applied mode changes |

## Verification
Every data output is due exactly one clock after the inputs it copies. The mode that routes a dword is the one applied before the edge at which that dword is captured. `modeChg` rises in the cycle after the edge at which the change is applied. The driver sets inputs at the falling edge and pushes the expected outputs for the coming rising edge, using its own model of the applied mode. The monitor pops and compares each expected item shortly after that rising edge, so every comparison lands one register stage after its stimulus. Mode requests are issued both in busy cycles and in idle cycles, so the checks cover held requests as well as applied ones.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [1:0] {
    LB_NONE    = 2'd0,
    LB_SHALLOW = 2'd1,
    LB_DEEP    = 2'd2
  } lbMode_e;

  typedef logic [3:0] portIdx_t;

  typedef struct packed {
    lbMode_e  mode;
    portIdx_t sel;
    logic     bypass;
  } lbCfg_t;
endpackage

// File: rtl/lb_ctrl.sv
module lb_ctrl
  import lb_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shallowEn,
  input  logic [NPORT-1:0] deepEnMask,
  input  logic             deepBypass,
  input  logic             hostRxValid,
  output lbCfg_t           cfg,
  output logic             modeChg
);
  lbCfg_t req;

  // Build the requested config; host-side loopback has priority, lowest port wins.
  always_comb begin
    req = '0;
    if (shallowEn) begin
      req.mode = LB_SHALLOW;
    end else if (|deepEnMask) begin
      req.mode   = LB_DEEP;
      req.bypass = deepBypass;
      for (int i = NPORT - 1; i >= 0; i--) begin
        if (deepEnMask[i]) req.sel = portIdx_t'(i);
      end
    end
  end

  // Apply only in an idle cycle between host dwords.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg     <= '0;
      modeChg <= 1'b0;
    end else begin
      modeChg <= 1'b0;
      if ((req != cfg) && !hostRxValid) begin
        cfg     <= req;
        modeChg <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lb_datapath.sv
module lb_datapath
  import lb_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int W     = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  lbCfg_t             cfg,
  input  logic [W-1:0]       hostRxData,
  input  logic               hostRxValid,
  output logic [W-1:0]       hostTxData,
  output logic               hostTxValid,
  output logic [W-1:0]       muxInData,
  output logic               muxInValid,
  input  logic [W-1:0]       muxUpData,
  input  logic               muxUpValid,
  input  logic [NPORT*W-1:0] muxDownData,
  input  logic [NPORT-1:0]   muxDownValid,
  output logic [NPORT*W-1:0] devTxData,
  output logic [NPORT-1:0]   devTxValid
);
  logic [W-1:0] selDownData;
  logic         selDownValid;
  logic [W-1:0] hostNextData;
  logic         hostNextValid;

  always_comb begin
    selDownData  = '0;
    selDownValid = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (cfg.sel == portIdx_t'(i)) begin
        selDownData  = muxDownData[i*W +: W];
        selDownValid = muxDownValid[i];
      end
    end
  end

  always_comb begin
    unique case (cfg.mode)
      LB_SHALLOW: begin
        hostNextData  = hostRxData;
        hostNextValid = hostRxValid;
      end
      LB_DEEP: begin
        hostNextData  = cfg.bypass ? hostRxData  : selDownData;
        hostNextValid = cfg.bypass ? hostRxValid : selDownValid;
      end
      default: begin
        hostNextData  = muxUpData;
        hostNextValid = muxUpValid;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostTxData  <= '0;
      hostTxValid <= 1'b0;
      muxInData   <= '0;
      muxInValid  <= 1'b0;
    end else begin
      hostTxData  <= hostNextData;
      hostTxValid <= hostNextValid;
      muxInData   <= hostRxData;
      muxInValid  <= hostRxValid;
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : gDev
    logic takeHost;
    assign takeHost = (cfg.mode == LB_DEEP) && cfg.bypass && (cfg.sel == portIdx_t'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        devTxData[g*W +: W] <= '0;
        devTxValid[g]       <= 1'b0;
      end else begin
        devTxData[g*W +: W] <= takeHost ? hostRxData  : muxDownData[g*W +: W];
        devTxValid[g]       <= takeHost ? hostRxValid : muxDownValid[g];
      end
    end
  end
endmodule

// File: rtl/loopback_sel.sv
module loopback_sel
  import lb_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int W     = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               shallowEn,
  input  logic [NPORT-1:0]   deepEnMask,
  input  logic               deepBypass,
  input  logic [W-1:0]       hostRxData,
  input  logic               hostRxValid,
  output logic [W-1:0]       hostTxData,
  output logic               hostTxValid,
  output logic [W-1:0]       muxInData,
  output logic               muxInValid,
  input  logic [W-1:0]       muxUpData,
  input  logic               muxUpValid,
  input  logic [NPORT*W-1:0] muxDownData,
  input  logic [NPORT-1:0]   muxDownValid,
  output logic [NPORT*W-1:0] devTxData,
  output logic [NPORT-1:0]   devTxValid,
  output logic               modeChg
);
  lbCfg_t cfg;

  lb_ctrl #(.NPORT(NPORT)) uCtrl (
    .clk(clk), .rstN(rstN), .shallowEn(shallowEn), .deepEnMask(deepEnMask),
    .deepBypass(deepBypass), .hostRxValid(hostRxValid), .cfg(cfg), .modeChg(modeChg)
  );

  lb_datapath #(.NPORT(NPORT), .W(W)) uData (
    .clk(clk), .rstN(rstN), .cfg(cfg),
    .hostRxData(hostRxData), .hostRxValid(hostRxValid),
    .hostTxData(hostTxData), .hostTxValid(hostTxValid),
    .muxInData(muxInData), .muxInValid(muxInValid),
    .muxUpData(muxUpData), .muxUpValid(muxUpValid),
    .muxDownData(muxDownData), .muxDownValid(muxDownValid),
    .devTxData(devTxData), .devTxValid(devTxValid)
  );
endmodule

// File: rtl/lb_chk.sv
module lb_chk
  import lb_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int W     = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               shallowEn,
  input logic               hostRxValid,
  input logic [W-1:0]       hostRxData,
  input logic [W-1:0]       hostTxData,
  input logic [W-1:0]       muxUpData,
  input logic [NPORT*W-1:0] muxDownData,
  input lbCfg_t             cfg,
  input logic               modeChg
);
  logic [W-1:0] chkSel;
  always_comb begin
    chkSel = '0;
    for (int i = 0; i < NPORT; i++)
      if (cfg.sel == portIdx_t'(i)) chkSel = muxDownData[i*W +: W];
  end

  a_r1_transparent: assert property (@(posedge clk) disable iff (!rstN)
    cfg.mode == LB_NONE |=> hostTxData == $past(muxUpData));
  a_r2_shallow_echo: assert property (@(posedge clk) disable iff (!rstN)
    cfg.mode == LB_SHALLOW |=> hostTxData == $past(hostRxData));
  a_r4_deep_turn: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode == LB_DEEP && !cfg.bypass) |=> hostTxData == $past(chkSel));
  a_r7_shallow_wins: assert property (@(posedge clk) disable iff (!rstN)
    (shallowEn && !hostRxValid) |=> cfg.mode == LB_SHALLOW);
  a_r8_idle_only: assert property (@(posedge clk) disable iff (!rstN)
    hostRxValid |=> $stable(cfg));
  a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rstN)
    !modeChg |-> $stable(cfg));
endmodule

bind loopback_sel lb_chk #(.NPORT(NPORT), .W(W)) uChk (
  .clk(clk), .rstN(rstN), .shallowEn(shallowEn), .hostRxValid(hostRxValid),
  .hostRxData(hostRxData), .hostTxData(hostTxData), .muxUpData(muxUpData),
  .muxDownData(muxDownData), .cfg(cfg), .modeChg(modeChg)
);

// File: tb/tb_loopback_sel.sv
module tb_loopback_sel;
  localparam int NPORT = 4;
  localparam int W     = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rstN;
  logic               shallowEn, deepBypass, hostRxValid, muxUpValid;
  logic [NPORT-1:0]   deepEnMask, muxDownValid, devTxValid;
  logic [W-1:0]       hostRxData, muxUpData, hostTxData, muxInData;
  logic [NPORT*W-1:0] muxDownData, devTxData;
  logic               hostTxValid, muxInValid, modeChg;

  loopback_sel #(.NPORT(NPORT), .W(W)) dut (.*);

  typedef struct packed {
    logic [W-1:0]       hData;
    logic               hValid;
    logic [W-1:0]       iData;
    logic               iValid;
    logic [NPORT*W-1:0] dData;
    logic [NPORT-1:0]   dValid;
    logic               chg;
  } exp_t;

  exp_t  qExp[$];
  string qTag[$];
  int    total = 0;
  int    bad   = 0;
  int    seq   = 0;

  // Bench model of the applied mode: 0 none, 1 host-side, 2 device-side.
  int mMode = 0, mSel = 0;
  bit mByp = 0;

  task automatic chk(string tag, logic [NPORT*W-1:0] act, logic [NPORT*W-1:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit sh, logic [NPORT-1:0] mask, bit byp, bit rv, string tag);
    exp_t e;
    int rMode, rSel;
    bit rByp;
    @(negedge clk);
    seq++;
    shallowEn   = sh;
    deepEnMask  = mask;
    deepBypass  = byp;
    hostRxValid = rv;
    hostRxData  = 32'hA500_0000 + seq;
    muxUpValid  = seq[0];
    muxUpData   = 32'hB600_0000 + seq;
    for (int i = 0; i < NPORT; i++) begin
      muxDownData[i*W +: W] = 32'hC000_0000 | (i << 20) | seq;
      muxDownValid[i]       = seq[i % 2] ^ i[0];
    end
    // expected outputs from the mode in force before this edge
    e.iData  = hostRxData;
    e.iValid = hostRxValid;
    e.dData  = muxDownData;
    e.dValid = muxDownValid;
    if (mMode == 1) begin
      e.hData = hostRxData; e.hValid = hostRxValid;
    end else if (mMode == 2) begin
      if (mByp) begin
        e.hData = hostRxData; e.hValid = hostRxValid;
        e.dData[mSel*W +: W] = hostRxData;
        e.dValid[mSel]       = hostRxValid;
      end else begin
        e.hData = muxDownData[mSel*W +: W]; e.hValid = muxDownValid[mSel];
      end
    end else begin
      e.hData = muxUpData; e.hValid = muxUpValid;
    end
    // requested mode
    rMode = 0; rSel = 0; rByp = 0;
    if (sh) rMode = 1;
    else if (mask != 0) begin
      rMode = 2; rByp = byp;
      for (int i = NPORT - 1; i >= 0; i--) if (mask[i]) rSel = i;
    end
    e.chg = 1'b0;
    if (!rv && (rMode != mMode || rSel != mSel || rByp != mByp)) begin
      e.chg = 1'b1;
      mMode = rMode; mSel = rSel; mByp = rByp;
    end
    qExp.push_back(e);
    qTag.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (qExp.size() > 0) begin
        exp_t e;
        string t;
        e = qExp.pop_front();
        t = qTag.pop_front();
        chk(t, {{(NPORT-1)*W{1'b0}}, hostTxData}, {{(NPORT-1)*W{1'b0}}, e.hData}, "hostTxData");
        chk(t, {{NPORT*W-1{1'b0}}, hostTxValid}, {{NPORT*W-1{1'b0}}, e.hValid}, "hostTxValid");
        chk(t, devTxData, e.dData, "devTxData");
        chk(t, {{NPORT*W-NPORT{1'b0}}, devTxValid}, {{NPORT*W-NPORT{1'b0}}, e.dValid}, "devTxValid");
        chk("R3", {{(NPORT-1)*W{1'b0}}, muxInData}, {{(NPORT-1)*W{1'b0}}, e.iData}, "muxInData");
        chk("R3", {{NPORT*W-1{1'b0}}, muxInValid}, {{NPORT*W-1{1'b0}}, e.iValid}, "muxInValid");
        chk("R9", {{NPORT*W-1{1'b0}}, modeChg}, {{NPORT*W-1{1'b0}}, e.chg}, "modeChg");
      end
    end
  end

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; shallowEn = 0; deepEnMask = '0; deepBypass = 0;
    hostRxValid = 0; hostRxData = '0; muxUpValid = 0; muxUpData = '0;
    muxDownData = '0; muxDownValid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10", {{(NPORT-1)*W{1'b0}}, hostTxData}, '0, "hostTxData");
    chk("R10", devTxData, '0, "devTxData");
    chk("R10", {{NPORT*W-1{1'b0}}, modeChg}, '0, "modeChg");
    rstN = 1'b1;
    // R1: transparent
    repeat (4) step(0, 4'b0000, 0, 1, "R1");
    // R8: host-side request held off by busy dwords
    repeat (3) step(1, 4'b0000, 0, 1, "R8");
    step(1, 4'b0000, 0, 0, "R9");
    // R2: host-side loopback echo
    repeat (4) step(1, 4'b0000, 0, 1, "R2");
    // R7: device requests ignored while host-side requested, including idle
    step(1, 4'b0110, 1, 0, "R7");
    repeat (3) step(1, 4'b0110, 1, 1, "R7");
    // R6/R4: lowest port of 0110 is 1
    step(0, 4'b0110, 0, 0, "R6");
    repeat (4) step(0, 4'b0110, 0, 1, "R4");
    step(0, 4'b1000, 0, 0, "R6");
    repeat (3) step(0, 4'b1000, 0, 1, "R4");
    // R5: bypass on port 2 (lowest of 1100)
    step(0, 4'b1100, 1, 0, "R5");
    repeat (4) step(0, 4'b1100, 1, 1, "R5");
    step(0, 4'b1100, 1, 0, "R5");
    // back to transparent
    step(0, 4'b0000, 0, 0, "R1");
    repeat (4) step(0, 4'b0000, 0, 1, "R1");
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule